// File: doc/BRIEF.md
# Hypervisor Interrupt Queue Pointer Bank

This block keeps the head and tail pointers of four hypervisor-managed interrupt queues: processor cross-calls, device interrupts, resumable errors and non-resumable errors. Software updates these pointers over a simple register bus. For three of the queues, a difference between head and tail means entries are waiting, and the block raises that queue's interrupt line. The non-resumable error queue is tracked in the same way but never raises a line.

The same bank also holds three other registers. The first is the hyperprivileged trap base address, whose low bits always read as zero. The second is a hyperprivileged state word; an identity bit in it is always set, and its contents drive a trap-level-zero request. The third is a read-only version word that reports the register-window count and the maximum trap and global levels.

Writes take effect at the clock edge. Reads are combinational from the address. The interrupt lines and the trap-level-zero request are derived from registered state. The queue contents and the trap dispatch logic are outside this block.

Top module: `hvq_bank`

## Requirements
- R1: The bank accepts a write when `req_valid` and `req_write` are both high at a rising clock edge. Three queues raise interrupts: `queue_irq[0]` for cross-calls, `[1]` for device interrupts and `[2]` for resumable errors. Each line is high from the cycle after any write to either pointer of its pair for as long as that pair's head differs from its tail. Each line is low while head and tail are equal.
- R2: The non-resumable error pair (addresses 6 and 7) stores and reads back its pointers. `queue_irq[3]` stays 0 at all times.
- R3: The pointer map on `req_addr` is 0/1 = cross-call head/tail, 2/3 = device head/tail, 4/5 = resumable head/tail and 6/7 = non-resumable head/tail. A write stores the low PTR_W bits of `req_wdata`. A read returns the pointer zero-extended to DATA_W bits.
- R4: The trap base register is at address 8. A write stores the data with bits 14:0 cleared, so bits 14:0 of every read are 0.
- R5: The state register is at address 9. A write stores the data with bit 11 (the identity bit) forced to 1.
- R6: `tlz_req` is high exactly when state bit 0 is 1, `trap_lvl` is 0 and state bit 2 is 0. It follows `trap_lvl` in the same cycle.
- R7: A read of address 10 returns NWIN in bits 7:0, MAX_TL in bits 15:8 and MAX_GL in bits 16 and up, with all other bits 0.
- R8: A write to address 10, or to any address from 11 to 15, changes no register. It drives `wr_err` high for exactly the next cycle.
- R9: After reset, all pointers are 0 and `queue_irq` is 0. The trap base reads 0, the state reads only bit 11 set, and `wr_err` is 0.
- R10: A read of an address from 11 to 15 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | DATA_W | Write data |
| trap_lvl | input | TL_W | Current trap level |
| rd_data | output | DATA_W | Read data for `req_addr` (combinational) |
| queue_irq | output | 4 | Per-queue pending interrupt lines |
| tlz_req | output | 1 | Trap-level-zero request |
| wr_err | output | 1 | One-cycle flag for an illegal write |

## Verification
A corrupted pointer shows up in two places. It appears on `rd_data` as soon as the pair is addressed. It also shows up on the matching `queue_irq` bit in the cycle after the write that exposed the mismatch. A bad state word appears at once on `tlz_req` under the right `trap_lvl`. A missed mask on the trap base or the identity bit appears on the first read. A write that was wrongly accepted to the version address shows as a changed read and a missing `wr_err` one cycle later. The reference model is compared against every output on every clock, so any of these faults is reported in the cycle it first becomes visible.

// File: rtl/hvq_pkg.sv
package hvq_pkg;
  localparam int ADDR_W   = 4;
  localparam int NQ       = 4;
  localparam logic [ADDR_W-1:0] A_TBASE = 4'd8;
  localparam logic [ADDR_W-1:0] A_STATE = 4'd9;
  localparam logic [ADDR_W-1:0] A_VER   = 4'd10;
  localparam int ST_TLZ   = 0;
  localparam int ST_HPRIV = 2;
  localparam int ST_ID    = 11;
  localparam int TB_ZERO_BITS = 15;
endpackage

// File: rtl/hvq_ptr_pair.sv
module hvq_ptr_pair #(
  parameter int PTR_W  = 32,
  parameter bit RAISES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_head,
  input  logic             wr_tail,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             pending
);
  logic [PTR_W-1:0] head_d, tail_d;

  always_comb begin
    head_d = head;
    tail_d = tail;
    if (wr_head) head_d = wdata;
    if (wr_tail) tail_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (wr_head || wr_tail) begin
      head <= head_d;
      tail <= tail_d;
    end
  end

  generate
    if (RAISES) begin : g_raise
      assign pending = (head != tail);
    end else begin : g_quiet
      assign pending = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hvq_hstate.sv
module hvq_hstate
  import hvq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tbase,
  input  logic              wr_state,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TL_W-1:0]   trap_lvl,
  output logic [DATA_W-1:0] tbase,
  output logic [DATA_W-1:0] state,
  output logic              tlz_req
);
  localparam logic [DATA_W-1:0] TB_KEEP = ~((DATA_W'(1) << TB_ZERO_BITS) - DATA_W'(1));
  localparam logic [DATA_W-1:0] ID_SET  = DATA_W'(1) << ST_ID;

  logic [DATA_W-1:0] tbase_d, state_d;

  always_comb begin
    tbase_d = wdata & TB_KEEP;
    state_d = wdata | ID_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbase <= '0;
    end else if (wr_tbase) begin
      tbase <= tbase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ID_SET;
    end else if (wr_state) begin
      state <= state_d;
    end
  end

  assign tlz_req = state[ST_TLZ] && (trap_lvl == '0) && !state[ST_HPRIV];
endmodule

// File: rtl/hvq_bank.sv
module hvq_bank
  import hvq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PTR_W  = 32,
  parameter int TL_W   = 3,
  parameter int NWIN   = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TL_W-1:0]   trap_lvl,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        queue_irq,
  output logic              tlz_req,
  output logic              wr_err
);
  localparam logic [DATA_W-1:0] VERSION =
    DATA_W'(NWIN) | (DATA_W'(MAX_TL) << 8) | (DATA_W'(MAX_GL) << 16);

  logic              wr;
  logic              is_ptr;
  logic              illegal;
  logic              err_d;
  logic [PTR_W-1:0]  heads [NQ];
  logic [PTR_W-1:0]  tails [NQ];
  logic [NQ-1:0]     pend;
  logic [DATA_W-1:0] tbase, state;

  assign wr      = req_valid && req_write;
  assign is_ptr  = (req_addr < 4'(2*NQ));
  assign illegal = !is_ptr && (req_addr != A_TBASE) && (req_addr != A_STATE);

  genvar q;
  generate
    for (q = 0; q < NQ; q++) begin : g_pair
      hvq_ptr_pair #(.PTR_W(PTR_W), .RAISES(q != NQ-1)) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_head (wr && (req_addr == 4'(2*q))),
        .wr_tail (wr && (req_addr == 4'(2*q+1))),
        .wdata   (req_wdata[PTR_W-1:0]),
        .head    (heads[q]),
        .tail    (tails[q]),
        .pending (pend[q])
      );
    end
  endgenerate

  hvq_hstate #(.DATA_W(DATA_W), .TL_W(TL_W)) u_hstate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_tbase (wr && (req_addr == A_TBASE)),
    .wr_state (wr && (req_addr == A_STATE)),
    .wdata    (req_wdata),
    .trap_lvl (trap_lvl),
    .tbase    (tbase),
    .state    (state),
    .tlz_req  (tlz_req)
  );

  assign err_d = wr && illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= err_d;
  end

  assign queue_irq = pend;

  always_comb begin
    rd_data = '0;
    if (is_ptr) begin
      if (req_addr[0]) rd_data = DATA_W'(tails[req_addr[2:1]]);
      else             rd_data = DATA_W'(heads[req_addr[2:1]]);
    end else if (req_addr == A_TBASE) begin
      rd_data = tbase;
    end else if (req_addr == A_STATE) begin
      rd_data = state;
    end else if (req_addr == A_VER) begin
      rd_data = VERSION;
    end
  end
endmodule

// File: rtl/hvq_bank_checks.sv
module hvq_bank_checks
  import hvq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TL_W   = 3,
  parameter int NWIN   = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [3:0]        req_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [TL_W-1:0]   trap_lvl,
  input logic [3:0]        queue_irq,
  input logic              tlz_req,
  input logic              wr_err
);
  localparam logic [DATA_W-1:0] VER_EXP =
    DATA_W'(NWIN) | (DATA_W'(MAX_TL) << 8) | (DATA_W'(MAX_GL) << 16);

  assert_irq_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write) |-> $stable(queue_irq));
  assert_nonres_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_irq[3]);
  assert_tbase_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == A_TBASE) |-> (rd_data[TB_ZERO_BITS-1:0] == '0));
  assert_id_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == A_STATE) |-> rd_data[ST_ID]);
  assert_tlz_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlz_req |-> (trap_lvl == '0));
  assert_ver_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == A_VER) |-> (rd_data == VER_EXP));
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(req_valid && req_write));
endmodule

bind hvq_bank hvq_bank_checks #(
  .DATA_W(DATA_W), .TL_W(TL_W), .NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)
) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rd_data(rd_data), .trap_lvl(trap_lvl),
  .queue_irq(queue_irq), .tlz_req(tlz_req), .wr_err(wr_err)
);

// File: tb/hvq_bank_test.sv
module hvq_bank_test;
  localparam int DATA_W = 64;
  localparam int PTR_W  = 32;
  localparam int TL_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [3:0]        req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [TL_W-1:0]   trap_lvl;
  logic [DATA_W-1:0] rd_data;
  logic [3:0]        queue_irq;
  logic              tlz_req, wr_err;

  int errors = 0;
  int checks = 0;

  // reference state
  longint unsigned m_ptr [8];
  longint unsigned m_tb, m_st;
  bit              m_err;

  hvq_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .trap_lvl(trap_lvl),
    .rd_data(rd_data), .queue_irq(queue_irq), .tlz_req(tlz_req), .wr_err(wr_err)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%0d)", tag, act, exp, req_addr);
    end
  endtask

  function automatic longint unsigned model_read(input int a);
    if (a < 8)  return m_ptr[a];
    if (a == 8) return m_tb;
    if (a == 9) return m_st;
    if (a == 10) return 64'h0003_0608;
    return 0;
  endfunction

  task automatic compare_all();
    logic [3:0] irq;
    irq[0] = m_ptr[0] != m_ptr[1];
    irq[1] = m_ptr[2] != m_ptr[3];
    irq[2] = m_ptr[4] != m_ptr[5];
    irq[3] = 1'b0;
    check("R1 queue_irq", 64'(queue_irq), 64'(irq));
    check("R3 rd_data", rd_data, model_read(int'(req_addr)));
    check("R6 tlz_req", 64'(tlz_req),
          64'(m_st[0] && trap_lvl == 0 && !m_st[2]));
    check("R8 wr_err", 64'(wr_err), 64'(m_err));
  endtask

  task automatic model_edge();
    bit w;
    int a;
    w = req_valid && req_write;
    a = int'(req_addr);
    m_err = w && (a >= 10);
    if (w) begin
      if (a < 8)       m_ptr[a] = req_wdata & 64'hFFFF_FFFF;
      else if (a == 8) m_tb = req_wdata & ~64'h7FFF;
      else if (a == 9) m_st = req_wdata | 64'h800;
    end
  endtask

  // drive at negedge, step one edge, compare at next negedge
  task automatic step(input bit v, input bit w, input int a,
                      input longint unsigned d, input int tl);
    req_valid = v; req_write = w; req_addr = 4'(a); req_wdata = d; trap_lvl = TL_W'(tl);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic peek(input int a, input int tl);
    req_valid = 1'b0; req_write = 1'b0; req_addr = 4'(a); trap_lvl = TL_W'(tl);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_ptr[i] = 0;
    m_tb = 0; m_st = 64'h800; m_err = 0;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; trap_lvl = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 irq after reset", 64'(queue_irq), 0);
    check("R9 wr_err after reset", 64'(wr_err), 0);
    peek(9, 0); check("R9 state after reset", rd_data, 64'h800);
    peek(8, 0); check("R9 tbase after reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 cross-call queue
    step(1, 1, 0, 5, 1);
    check("R1 cpu irq raised", 64'(queue_irq[0]), 1);
    step(1, 1, 1, 5, 1);
    check("R1 cpu irq cleared", 64'(queue_irq[0]), 0);
    step(1, 1, 3, 9, 1);
    check("R1 device irq raised", 64'(queue_irq[1]), 1);
    step(1, 1, 4, 2, 1);
    check("R1 resumable irq raised", 64'(queue_irq[2]), 1);
    // R2 non-resumable stores but stays quiet
    step(1, 1, 6, 64'h1234_0000_0007, 1);
    check("R2 nonres irq quiet", 64'(queue_irq[3]), 0);
    peek(6, 1); check("R2 R3 nonres head readback truncated", rd_data, 64'h7);
    // R4 trap base masking
    step(1, 1, 8, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    peek(8, 1); check("R4 tbase low bits clear", rd_data, 64'hFFFF_FFFF_FFFF_8000);
    // R5 identity bit forced
    step(1, 1, 9, 64'h1, 0);
    peek(9, 0); check("R5 state id forced", rd_data, 64'h801);
    check("R6 tlz with tl zero", 64'(tlz_req), 1);
    peek(9, 2); check("R6 tlz blocked by tl", 64'(tlz_req), 0);
    step(1, 1, 9, 64'h5, 0);
    check("R6 tlz blocked by hpriv", 64'(tlz_req), 0);
    // R7 version and R8 illegal write
    step(1, 1, 10, 64'hDEAD, 0);
    check("R8 wr_err on version write", 64'(wr_err), 1);
    step(0, 0, 10, 0, 0);
    check("R8 wr_err one cycle", 64'(wr_err), 0);
    check("R7 version unchanged", rd_data, 64'h0003_0608);
    step(1, 1, 13, 64'h77, 0);
    check("R8 wr_err unmapped", 64'(wr_err), 1);
    peek(13, 0); check("R10 unmapped reads zero", rd_data, 0);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int a;
      a = int'($urandom % 16);
      step(($urandom % 4) != 0, ($urandom % 2) == 1, a,
           (a < 8) ? longint'($urandom % 4) : {$urandom, $urandom},
           int'($urandom % 3));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule